// File: doc/BRIEF.md
# Parallel Flash Programming Sequencer

This block is a behavioural model of the parallel programming port of a 4 KB on-chip code flash. An external programmer drives an address, a data byte and a mode code, and then gives a program pulse (active low). The block holds the array and answers verify and signature reads on a registered data-out bus. It runs byte writes, lock-bit writes and chip erase as self-timed operations, and a ready line shows when the array is busy.

A byte write or lock write starts when the program pulse ends. It then runs for a fixed number of clock cycles. While a byte write runs, reading the array returns a polling pattern in which bit 7 is the complement of the bit 7 being written. Chip erase is a separate mode. It needs a long program pulse, then sweeps the whole array to FFh one byte per cycle and clears the lock bits. All durations are clock-count parameters.

Top module: `pflash_seq`

## Requirements
- R1: While reset is high, `rdy` is 1 and `dout` is 00h.
- R2: Mode codes are 3'd1 verify read, 3'd2 byte program, 3'd3 chip erase, 3'd4 lock-bit program and 3'd6 signature read. A byte program stores the old byte ANDed with `din`, so it can only clear bits. A later verify read returns the stored byte.
- R3: For a program or lock write, `rdy` falls in the cycle after the end of the program pulse is seen. It stays low for exactly WRITE_CYC cycles.
- R4: While a byte write is in progress, a verify read returns bit 7 as the complement of the bit 7 being written. Bits 6:0 hold the byte as it was before the write.
- R5: An erase pulse held low for at least ERASE_HOLD cycles holds `rdy` low for DEPTH cycles. It leaves every byte at FFh and both lock bits cleared.
- R6: An erase pulse shorter than ERASE_HOLD cycles is ignored. `rdy` stays high and the array is unchanged.
- R7: With `hv_en` low, program, lock and erase pulses are ignored.
- R8: A pulse that ends while `rdy` is low is ignored.
- R9: Once any lock bit is programmed, a verify read returns FFh. The lock bit is selected by `addr[0]`.
- R10: A signature read returns 1Eh at 030h and 51h at 031h. At 032h it returns FFh when SIG_HV12 is 1, and 05h when it is 0. This holds regardless of the lock bits.
- R11: A read result appears on `dout` two clock edges after `mode` and `addr` are applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 12 | Byte address; bit 0 selects the lock bit in lock mode |
| din | input | 8 | Data byte to program |
| mode | input | 3 | Operation code |
| prog_n | input | 1 | Program pulse, active low |
| hv_en | input | 1 | High-voltage enable; write-type operations need it |
| dout | output | 8 | Registered read data |
| rdy | output | 1 | High when idle, low while a self-timed operation runs |

## Verification
A wrong sequencer state shows up on `rdy` within one cycle of the pulse end: the line falls when it should hold, or holds when it should fall. A wrong timer or sweep counter changes the length of the low period, which the bench measures to the exact cycle. A wrong merge or a stale lock bit is not visible until the next verify read. That read shows the wrong byte two edges after the address is applied. A wrong polling mux shows up on bit 7 during the busy window.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
  localparam logic [2:0] MD_NOP   = 3'd0;
  localparam logic [2:0] MD_READ  = 3'd1;
  localparam logic [2:0] MD_PROG  = 3'd2;
  localparam logic [2:0] MD_ERASE = 3'd3;
  localparam logic [2:0] MD_LOCK  = 3'd4;
  localparam logic [2:0] MD_SIG   = 3'd6;

  typedef enum logic [1:0] {S_IDLE, S_WRITE, S_LOCK, S_ERASE} seq_state_e;
endpackage

// File: rtl/pfs_pulse_mon.sv
module pfs_pulse_mon #(
  parameter int ERASE_HOLD = 1250000
) (
  input  logic clk,
  input  logic rst,
  input  logic prog_n,
  output logic pend,
  output logic long_ok
);
  localparam int CW = $clog2(ERASE_HOLD + 1);
  logic          prog_q;
  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      prog_q  <= 1'b1;
      low_cnt <= '0;
    end else begin
      prog_q <= prog_n;
      if (prog_n) low_cnt <= '0;
      else if (low_cnt != CW'(ERASE_HOLD)) low_cnt <= low_cnt + 1'b1;
    end
  end

  assign pend    = !prog_q && prog_n;
  assign long_ok = (low_cnt == CW'(ERASE_HOLD));
endmodule

// File: rtl/pfs_array.sv
module pfs_array #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] wa,
  input  logic [DATA_W-1:0] wd,
  input  logic [ADDR_W-1:0] ra,
  output logic [DATA_W-1:0] rq
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    rq <= mem[ra];
  end
endmodule

// File: rtl/pfs_readout.sv
module pfs_readout
  import pfs_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 8,
  parameter bit SIG_HV12 = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        rd_mode_q,
  input  logic [ADDR_W-1:0] rd_addr_q,
  input  logic [DATA_W-1:0] rq,
  input  logic              poll_q,
  input  logic              wbit_top,
  input  logic              lock_any,
  output logic [DATA_W-1:0] dout
);
  logic [DATA_W-1:0] sig_val, nxt;

  always_comb begin
    case (rd_addr_q)
      ADDR_W'(12'h030): sig_val = DATA_W'(8'h1E);
      ADDR_W'(12'h031): sig_val = DATA_W'(8'h51);
      ADDR_W'(12'h032): sig_val = SIG_HV12 ? DATA_W'(8'hFF) : DATA_W'(8'h05);
      default:          sig_val = '1;
    endcase
    if (rd_mode_q == MD_SIG)       nxt = sig_val;
    else if (rd_mode_q == MD_READ) begin
      if (poll_q)        nxt = {~wbit_top, rq[DATA_W-2:0]};
      else if (lock_any) nxt = '1;
      else               nxt = rq;
    end else               nxt = '1;
  end

  always_ff @(posedge clk) begin
    if (rst) dout <= '0;
    else     dout <= nxt;
  end
endmodule

// File: rtl/pflash_seq.sv
module pflash_seq
  import pfs_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 8,
  parameter int NLOCK      = 2,
  parameter int WRITE_CYC  = 187500,
  parameter int ERASE_HOLD = 1250000,
  parameter bit SIG_HV12   = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic [2:0]        mode,
  input  logic              prog_n,
  input  logic              hv_en,
  output logic [DATA_W-1:0] dout,
  output logic              rdy
);
  localparam int TW     = $clog2(WRITE_CYC);
  localparam int LSEL_W = (NLOCK > 1) ? $clog2(NLOCK) : 1;

  seq_state_e        st;
  logic [TW-1:0]     tmr;
  logic [ADDR_W-1:0] waddr, eaddr, ra, wa, rd_addr_q;
  logic [DATA_W-1:0] wdata, wd, rq;
  logic [LSEL_W-1:0] lsel;
  logic [NLOCK-1:0]  lock;
  logic [2:0]        rd_mode_q;
  logic              pend, long_ok, tmr_done, we, poll_q, lock_any;

  pfs_pulse_mon #(.ERASE_HOLD(ERASE_HOLD)) u_pmon (
    .clk(clk), .rst(rst), .prog_n(prog_n), .pend(pend), .long_ok(long_ok)
  );

  assign tmr_done = (tmr == TW'(WRITE_CYC - 1));
  assign lock_any = |lock;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; rdy <= 1'b1; tmr <= '0; waddr <= '0; wdata <= '0;
      lsel <= '0; eaddr <= '0; lock <= '0;
    end else begin
      case (st)
        S_IDLE: if (pend && hv_en) begin
          if (mode == MD_PROG) begin
            waddr <= addr; wdata <= din; tmr <= '0; st <= S_WRITE; rdy <= 1'b0;
          end else if (mode == MD_LOCK) begin
            lsel <= addr[LSEL_W-1:0]; tmr <= '0; st <= S_LOCK; rdy <= 1'b0;
          end else if (mode == MD_ERASE && long_ok) begin
            eaddr <= '0; st <= S_ERASE; rdy <= 1'b0;
          end
        end
        S_WRITE, S_LOCK: begin
          if (tmr_done) begin
            if (st == S_LOCK) lock[lsel] <= 1'b1;
            st <= S_IDLE; rdy <= 1'b1;
          end else tmr <= tmr + 1'b1;
        end
        S_ERASE: begin
          if (eaddr == '1) begin
            lock <= '0; st <= S_IDLE; rdy <= 1'b1;
          end else eaddr <= eaddr + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    we = (st == S_ERASE) || (st == S_WRITE && tmr_done);
    wa = (st == S_ERASE) ? eaddr : waddr;
    wd = (st == S_ERASE) ? '1 : (rq & wdata);
    ra = (st == S_WRITE) ? waddr : addr;
  end

  pfs_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
    .clk(clk), .we(we), .wa(wa), .wd(wd), .ra(ra), .rq(rq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_mode_q <= MD_NOP; rd_addr_q <= '0; poll_q <= 1'b0;
    end else begin
      rd_mode_q <= mode; rd_addr_q <= addr; poll_q <= (st == S_WRITE);
    end
  end

  pfs_readout #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIG_HV12(SIG_HV12)) u_out (
    .clk(clk), .rst(rst), .rd_mode_q(rd_mode_q), .rd_addr_q(rd_addr_q),
    .rq(rq), .poll_q(poll_q), .wbit_top(wdata[DATA_W-1]),
    .lock_any(lock_any), .dout(dout)
  );
endmodule

// File: rtl/pfs_checker.sv
module pfs_checker
  import pfs_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              hv_en,
  input logic [2:0]        mode,
  input logic              rdy,
  input logic [DATA_W-1:0] dout,
  input logic              pend,
  input logic              long_ok,
  input logic              lock_any,
  input logic [2:0]        rd_mode_q,
  input logic [ADDR_W-1:0] rd_addr_q,
  input logic              poll_q
);
  AST_PROG_STARTS_BUSY: assert property (@(posedge clk) disable iff (rst)
    pend && hv_en && mode == MD_PROG && rdy |=> !rdy); // R3
  AST_SHORT_ERASE_IDLE: assert property (@(posedge clk) disable iff (rst)
    pend && mode == MD_ERASE && !long_ok && rdy |=> rdy); // R6
  AST_NO_HV_IDLE: assert property (@(posedge clk) disable iff (rst)
    pend && !hv_en && rdy |=> rdy); // R7
  AST_LOCKED_READ_BLANK: assert property (@(posedge clk) disable iff (rst)
    $past(lock_any) && $past(rd_mode_q) == MD_READ && !$past(poll_q)
    |-> dout == '1); // R9
  AST_SIG_FIRST: assert property (@(posedge clk) disable iff (rst)
    $past(rd_mode_q) == MD_SIG && $past(rd_addr_q) == ADDR_W'(12'h030)
    |-> dout == DATA_W'(8'h1E)); // R10
  AST_SIG_SECOND: assert property (@(posedge clk) disable iff (rst)
    $past(rd_mode_q) == MD_SIG && $past(rd_addr_q) == ADDR_W'(12'h031)
    |-> dout == DATA_W'(8'h51)); // R10
endmodule

bind pflash_seq pfs_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .hv_en(hv_en), .mode(mode), .rdy(rdy), .dout(dout),
  .pend(pend), .long_ok(long_ok), .lock_any(lock_any),
  .rd_mode_q(rd_mode_q), .rd_addr_q(rd_addr_q), .poll_q(poll_q)
);

// File: tb/sim_pflash_seq.sv
module sim_pflash_seq;
  localparam int W     = 20;
  localparam int HOLD  = 30;
  localparam int DEPTH = 4096;
  localparam logic [2:0] M_READ = 3'd1, M_PROG = 3'd2, M_ERASE = 3'd3,
                         M_LOCK = 3'd4, M_SIG = 3'd6;

  logic clk = 0, rst = 1, prog_n = 1, hv_en = 1, rdy;
  logic [11:0] addr = '0;
  logic [7:0]  din = '0, dout;
  logic [2:0]  mode = '0;
  int checks = 0, errors = 0;
  bit done = 0;

  logic [7:0] exp_q [$];
  string      tag_q [$];
  event       smp;

  always #4 clk = ~clk;

  pflash_seq #(.WRITE_CYC(W), .ERASE_HOLD(HOLD)) u0 (
    .clk(clk), .rst(rst), .addr(addr), .din(din), .mode(mode),
    .prog_n(prog_n), .hv_en(hv_en), .dout(dout), .rdy(rdy)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected items and compares with dout
  initial forever begin
    @(smp);
    chk(tag_q.pop_front(), int'(dout), int'(exp_q.pop_front()));
  end

  // driver: R11 read result two edges after mode/addr applied
  task automatic rd(input logic [2:0] m, input logic [11:0] a,
                    input logic [7:0] e, input string tag);
    @(negedge clk); mode = m; addr = a;
    repeat (3) @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(tag);
    -> smp;
  endtask

  task automatic pulse(input logic [2:0] m, input logic [11:0] a,
                       input logic [7:0] d, input int n);
    @(negedge clk); mode = m; addr = a; din = d; prog_n = 0;
    repeat (n) @(negedge clk);
    prog_n = 1;
  endtask

  task automatic busy_len(output int n);
    n = 0;
    @(negedge clk);
    while (!rdy) begin n++; @(negedge clk); end
  endtask

  task automatic wait_rdy();
    @(negedge clk);
    while (!rdy) @(negedge clk);
  endtask

  initial begin
    int n;
    repeat (4) @(negedge clk);
    chk("R1 rdy in reset", int'(rdy), 1);
    chk("R1 dout in reset", int'(dout), 8'h00);
    rst = 0;

    pulse(M_ERASE, 0, 0, HOLD + 5); busy_len(n);
    chk("R5 erase busy length", n, DEPTH);
    rd(M_READ, 12'h005, 8'hFF, "R5 erased low");
    rd(M_READ, 12'hFFF, 8'hFF, "R5 erased top");

    pulse(M_PROG, 12'h005, 8'hA5, 2);
    rd(M_READ, 12'h005, 8'h7F, "R4 polling bit 7");
    pulse(M_PROG, 12'h006, 8'h00, 2);
    wait_rdy();
    rd(M_READ, 12'h006, 8'hFF, "R8 busy pulse ignored");
    rd(M_READ, 12'h005, 8'hA5, "R2 program");

    pulse(M_PROG, 12'hFFF, 8'h12, 2); busy_len(n);
    chk("R3 write busy length", n, W);
    rd(M_READ, 12'hFFF, 8'h12, "R2 program top");

    pulse(M_PROG, 12'h005, 8'h3C, 2); wait_rdy();
    rd(M_READ, 12'h005, 8'h24, "R2 AND merge");

    hv_en = 0;
    pulse(M_PROG, 12'h010, 8'h00, 2); @(negedge clk);
    chk("R7 no hv program rdy", int'(rdy), 1);
    pulse(M_ERASE, 0, 0, HOLD + 5); @(negedge clk);
    chk("R7 no hv erase rdy", int'(rdy), 1);
    hv_en = 1;
    rd(M_READ, 12'h010, 8'hFF, "R7 no hv program data");
    rd(M_READ, 12'h005, 8'h24, "R7 no hv erase data");

    pulse(M_ERASE, 0, 0, 10); @(negedge clk);
    chk("R6 short erase rdy", int'(rdy), 1);
    rd(M_READ, 12'h005, 8'h24, "R6 short erase data");

    rd(M_SIG, 12'h030, 8'h1E, "R10 sig 030");
    rd(M_SIG, 12'h031, 8'h51, "R10 sig 031");
    rd(M_SIG, 12'h032, 8'hFF, "R10 sig 032");

    pulse(M_LOCK, 12'h001, 0, 2); busy_len(n);
    chk("R3 lock busy length", n, W);
    rd(M_READ, 12'h005, 8'hFF, "R9 locked read");
    rd(M_SIG, 12'h030, 8'h1E, "R10 sig under lock");

    pulse(M_ERASE, 0, 0, HOLD + 5); busy_len(n);
    chk("R5 second erase length", n, DEPTH);
    rd(M_READ, 12'hFFF, 8'hFF, "R5 erased after data");
    pulse(M_PROG, 12'h005, 8'h3C, 2); wait_rdy();
    rd(M_READ, 12'h005, 8'h3C, "R5 lock cleared");

    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule